// File: doc/BRIEF.md
# Double-Word Funnel Shifter

This block shifts a 128-bit value made of two 64-bit words, a high word and a low word, by an amount taken modulo 64. A left shift returns the upper word of the shifted value and a right shift returns the lower word. The result is the same as a 128-bit shift, but the datapath is only 64 bits wide. A mask merges the two words into one, and a single rotator then moves the bits into place.

The caller offers three register values: the old destination value and two source operands. A 2-bit source-select field decides where the old destination value goes. It can stand in for the high word, the low word or the shift amount. In the fourth mode one data word is forced to zero. For a left shift the forced word is the high word, and for a right shift it is the low word.

A strobe loads the operands, the direction bit and the select field. The result appears in a register one clock later. A two-state controller marks when the result is fresh. In state `ST_IDLE`, a strobe moves the controller to `ST_LOADED`, and no strobe keeps it in `ST_IDLE`. In state `ST_LOADED`, a strobe keeps it there, and no strobe returns it to `ST_IDLE`.

Top module: `dws_funnel`

## Requirements
- R1: While reset is held (`rst_n` low), and in the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high. `result` keeps its value through any cycle in which `in_valid` is low, whatever the other inputs do.
- R3: With `dir` = 0 (left), `result` equals the upper 64 bits of ({hi,lo} << n), where n is bits [5:0] of the shift operand. Bits [63:6] of the shift operand have no effect, so an amount of 64 or more is never treated as zeroing.
- R4: With `dir` = 1 (right), `result` equals the lower 64 bits of ({hi,lo} >> n), with n formed as in R3.
- R5: When n = 0, a left shift returns hi and a right shift returns lo.
- R6: `src_sel` = 2'b00: hi = `dest_old`, lo = `op_a`, shift operand = `op_b`.
- R7: `src_sel` = 2'b01: hi = `op_a`, lo = `dest_old`, shift operand = `op_b`.
- R8: `src_sel` = 2'b10: hi = `op_a`, lo = `op_b`, shift operand = `dest_old`.
- R9: `src_sel` = 2'b11 with `dir` = 0: hi = 0, lo = `op_a`, shift operand = `op_b`.
- R10: `src_sel` = 2'b11 with `dir` = 1: hi = `op_a`, lo = 0, shift operand = `op_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load strobe for operands, direction and select |
| dir | input | 1 | Shift direction: 0 left, 1 right |
| src_sel | input | 2 | Role of `dest_old`: 00 high word, 01 low word, 10 shift amount, 11 zero-word mode |
| dest_old | input | 64 | Previous destination value |
| op_a | input | 64 | First source operand |
| op_b | input | 64 | Second source operand |
| out_valid | output | 1 | Result is fresh this cycle |
| result | output | 64 | Registered shift result |

## Verification
A wrong operand route or a wrong mask shows up in `result` one cycle after the strobe. It appears as bits taken from the wrong word or from the wrong side of the split point. A mask off by one position shows up only for some shift amounts, so every amount from 0 to 63 is run in every mode. A controller stuck in the wrong state shows up the cycle after a strobe or after an idle cycle: `out_valid` has the wrong level, or `result` moves while no strobe is given. All shift amounts are compared against a 128-bit model computed in the bench.

// File: rtl/dws_pkg.sv
package dws_pkg;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        SRC_DEST_HI  = 2'b00,
        SRC_DEST_LO  = 2'b01,
        SRC_DEST_AMT = 2'b10,
        SRC_ZERO     = 2'b11
    } src_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } state_e;

endpackage

// File: rtl/dws_route.sv
module dws_route
    import dws_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         dir,
    input  logic [1:0]   src_sel,
    input  logic [W-1:0] dest_old,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] hi_word,
    output logic [W-1:0] lo_word,
    output logic [W-1:0] amt_word
);
    always_comb begin
        hi_word  = op_a;
        lo_word  = op_b;
        amt_word = op_b;
        unique case (src_e'(src_sel))
            SRC_DEST_HI: begin
                hi_word = dest_old;
                lo_word = op_a;
            end
            SRC_DEST_LO: begin
                hi_word = op_a;
                lo_word = dest_old;
            end
            SRC_DEST_AMT: begin
                hi_word  = op_a;
                lo_word  = op_b;
                amt_word = dest_old;
            end
            SRC_ZERO: begin
                if (dir_e'(dir) == DIR_LEFT) begin
                    hi_word = '0;
                    lo_word = op_a;
                end else begin
                    hi_word = op_a;
                    lo_word = '0;
                end
            end
        endcase
    end
endmodule

// File: rtl/dws_rotl.sv
module dws_rotl #(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [0:SW];

    assign stage[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stage[k+1] = amt[k] ? ((stage[k] << S) | (stage[k] >> (W - S)))
                                   : stage[k];
    end

    assign dout = stage[SW];
endmodule

// File: rtl/dws_merge_rot.sv
module dws_merge_rot
    import dws_pkg::*;
#(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic          dir,
    input  logic [W-1:0]  hi_word,
    input  logic [W-1:0]  lo_word,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  shifted
);
    logic [W-1:0]  ones;
    logic [W-1:0]  hi_mask;
    logic [W-1:0]  merged;
    logic [SW-1:0] rot_amt;

    assign ones = '1;

    always_comb begin
        if (dir_e'(dir) == DIR_LEFT) begin
            hi_mask = ones >> amt;
            rot_amt = amt;
        end else begin
            hi_mask = ~(ones << amt);
            rot_amt = SW'(0) - amt;
        end
        merged = (hi_word & hi_mask) | (lo_word & ~hi_mask);
    end

    dws_rotl #(.W(W)) u_rot (
        .din  (merged),
        .amt  (rot_amt),
        .dout (shifted)
    );
endmodule

// File: rtl/dws_funnel.sv
module dws_funnel
    import dws_pkg::*;
#(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         dir,
    input  logic [1:0]   src_sel,
    input  logic [W-1:0] dest_old,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         out_valid,
    output logic [W-1:0] result
);
    logic [W-1:0] hi_word;
    logic [W-1:0] lo_word;
    logic [W-1:0] amt_word;
    logic [W-1:0] shifted;
    state_e       state_q;
    state_e       state_d;

    dws_route #(.W(W)) u_route (
        .dir      (dir),
        .src_sel  (src_sel),
        .dest_old (dest_old),
        .op_a     (op_a),
        .op_b     (op_b),
        .hi_word  (hi_word),
        .lo_word  (lo_word),
        .amt_word (amt_word)
    );

    dws_merge_rot #(.W(W)) u_core (
        .dir     (dir),
        .hi_word (hi_word),
        .lo_word (lo_word),
        .amt     (amt_word[SW-1:0]),
        .shifted (shifted)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (in_valid) result <= shifted;
    end

    assign out_valid = (state_q == ST_LOADED);
endmodule

// File: rtl/dws_funnel_chk.sv
module dws_funnel_chk #(
    parameter int W = 64,
    localparam int SW = $clog2(W)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         dir,
    input logic [1:0]   src_sel,
    input logic [W-1:0] dest_old,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         out_valid,
    input logic [W-1:0] result
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R2
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));  // R2
    AST_LEFT_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir && src_sel == 2'b00 && op_b[SW-1:0] == '0)
        |=> result == $past(dest_old));  // R5
    AST_RIGHT_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir && src_sel == 2'b01 && op_b[SW-1:0] == '0)
        |=> result == $past(dest_old));  // R7
    AST_AMT_FROM_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir && src_sel == 2'b10 && dest_old[SW-1:0] == '0)
        |=> result == $past(op_b));  // R8
    AST_ZERO_HI_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir && src_sel == 2'b11 && op_b[SW-1:0] == '0)
        |=> result == '0);  // R9
endmodule

bind dws_funnel dws_funnel_chk #(.W(W)) u_chk (.*);

// File: tb/dws_funnel_test.sv
module dws_funnel_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         dir = 1'b0;
    logic [1:0]   src_sel = 2'b00;
    logic [W-1:0] dest_old = '0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dws_funnel #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dir(dir),
        .src_sel(src_sel), .dest_old(dest_old), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [63:0] model(input logic d, input logic [1:0] s,
                                          input logic [63:0] dst,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] hi, lo, sh;
        logic [127:0] v;
        int n;
        case (s)
            2'b00: begin hi = dst; lo = a; sh = b; end
            2'b01: begin hi = a; lo = dst; sh = b; end
            2'b10: begin hi = a; lo = b; sh = dst; end
            default: begin
                sh = b;
                if (!d) begin hi = 64'd0; lo = a; end
                else    begin hi = a; lo = 64'd0; end
            end
        endcase
        n = int'(sh[5:0]);
        v = {hi, lo};
        if (!d) begin
            v = v << n;
            return v[127:64];
        end
        v = v >> n;
        return v[63:0];
    endfunction

    function automatic string tag_of(input logic d, input logic [1:0] s);
        case (s)
            2'b00: return d ? "R4/R6" : "R3/R6";
            2'b01: return d ? "R4/R7" : "R3/R7";
            2'b10: return d ? "R4/R8" : "R3/R8";
            default: return d ? "R10" : "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic d, input logic [1:0] s,
                          input logic [63:0] dst, input logic [63:0] a,
                          input logic [63:0] b, input string tag);
        logic [63:0] exp;
        exp = model(d, s, dst, a, b);
        @(negedge clk);
        in_valid = 1'b1; dir = d; src_sel = s;
        dest_old = dst; op_a = a; op_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " out_valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, result, exp);
    endtask

    initial begin
        logic [63:0] held;
        int seed_dummy;
        seed_dummy = int'($urandom(32'h5eed));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 after reset result", result, 64'd0);

        // R5: zero amount gives hi (left) or lo (right)
        run_op(1'b0, 2'b00, 64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_FFFF_0000,
               64'd0, "R5 left n=0");
        run_op(1'b1, 2'b00, 64'hDEAD_BEEF_0123_4567, 64'hA5A5_5A5A_1234_8765,
               64'd0, "R5 right n=0");
        // R3: amount 64 and large values are taken mod 64, never zeroing
        run_op(1'b0, 2'b00, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
               64'd64, "R3 amount 64");
        run_op(1'b0, 2'b01, 64'h8000_0000_0000_0001, 64'hC000_0000_0000_0003,
               64'hFFFF_FFFF_FFFF_FFC1, "R3 upper amount bits");
        run_op(1'b1, 2'b10, 64'h0000_0000_0000_013F, 64'h8000_0000_0000_0000,
               64'h0000_0000_0000_0001, "R4 amount 63");
        run_op(1'b0, 2'b11, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R9 n=1");
        run_op(1'b1, 2'b11, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R10 n=1");

        // R2: no strobe, inputs wander, result must hold
        held = result;
        @(negedge clk);
        in_valid = 1'b0; dir = ~dir; src_sel = 2'b10;
        dest_old = rnd64(); op_a = rnd64(); op_b = rnd64();
        @(negedge clk);
        check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R2 idle result held", result, held);

        // every amount, every mode, both directions
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 4; s++)
                for (int n = 0; n < 64; n++) begin
                    logic [63:0] dst, a, b;
                    dst = rnd64(); a = rnd64(); b = rnd64();
                    if (s == 2) dst = {dst[63:6], 6'(n)};
                    else        b   = {b[63:6], 6'(n)};
                    run_op(d[0], s[1:0], dst, a, b, tag_of(d[0], s[1:0]));
                end

        // random mix with idle gaps
        for (int i = 0; i < 1500; i++) begin
            logic d;
            logic [1:0] s;
            d = $urandom_range(0, 1) != 0;
            s = 2'($urandom_range(0, 3));
            run_op(d, s, rnd64(), rnd64(), rnd64(), tag_of(d, s));
            if ($urandom_range(0, 7) == 0) begin
                held = result;
                @(negedge clk);
                dest_old = rnd64(); op_a = rnd64(); op_b = rnd64();
                @(negedge clk);
                check("R2 gap result held", result, held);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end
endmodule